// File: doc/BRIEF.md
# Keyboard Wake-Up Interrupt Controller

This block watches one port of active-low key inputs and raises a single interrupt request when a key is pressed. Software picks which pins take part through an enable register. The enabled pins are combined into one "all released" signal after a two-flop synchronizer. A single request latch is set from that signal, either on its falling edge only or on falling edges and on a held low level. The latch drives a pending flag and, through a mask, the interrupt request output. Each enabled pin also asserts a pull-up enable output toward the pad.

Software reaches the block through a two-location register port with plain write strobes and a combinational read. Location 0 is control and status. Location 1 is the pin enable register. An acknowledge written to control clears the latch. A debug break input blocks that acknowledge unless the break-clear-enable input is high. The safe way to bring the block up is to set the mask, enable the pins, acknowledge any false request that enabling a held-low pin caused, and then clear the mask.

Top module: `kbw_irq_ctrl`

## Requirements
- R1: After reset, pend, irq and pullup_en are 0, and both register locations read 0.
- R2: Location 1 (reg_addr=1) holds the pin enable bits. It reads back what was written. A pin whose enable bit is 0 never sets the latch.
- R3: pullup_en[i] equals the enable bit of pin i.
- R4: In edge mode (control bit 0 = 0), a falling key input on an enabled pin, with all other enabled pins high, sets pend exactly 3 clock edges after the input changes.
- R5: In edge mode, a falling edge on one enabled pin does not set the latch while any other enabled pin is already low.
- R6: In level mode (control bit 0 = 1), any enabled pin held low sets pend. An acknowledge has no effect while any enabled pin is low. Once all enabled pins are high, an acknowledge clears pend.
- R7: Writing control with bit 2 = 1 acknowledges the request and clears pend (edge mode). Bit 2 always reads 0.
- R8: An acknowledge has no effect while dbg_break=1 and brk_clr_en=0. It takes effect while dbg_break=1 and brk_clr_en=1.
- R9: Control bit 1 is the mask. When the mask is 1, irq stays 0 but pend can still be set. Otherwise irq equals pend.
- R10: Location 0 reads as follows: bit 0 is the mode, bit 1 is the mask, bit 2 is 0, bit 3 is pend (read-only), and bits 7:4 are 0.
- R11: Enabling a pin that is already low raises a false request. With the mask set, this request does not reach irq, and an acknowledge clears it before the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n | input | N_KEYS | Active-low key inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = pin enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| dbg_break | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows acknowledges during a break |
| irq | output | 1 | Interrupt request, active high |
| pend | output | 1 | Request latch state |
| pullup_en | output | N_KEYS | Pull-up enable per pin |

## Verification
A wrong detector state shows up as pend rising without a qualifying edge, or missing one, on the third clock edge after a key change. A latch stuck in either state shows at the next acknowledge or the next key event, through pend and through status bit 3. A wrong mask or enable register shows at once on irq, pullup_en and the readback. The sweeps drop each pin alone and each pin after every other, so a detector that ORs the pins instead of ANDing them, or that ignores the enable bits, fails on the first affected pair.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  localparam int CTL_MODE = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_ACK  = 2;
  localparam int CTL_PEND = 3;
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_EN  = 1'b1;
endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/kbw_detect.sv
module kbw_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] keys_s,
  input  logic [N-1:0] en,
  output logic         all_high,
  output logic         fall
);
  logic [N-1:0] masked;
  logic         all_high_q;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g] = keys_s[g] | ~en[g];
  end

  assign all_high = &masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_high_q <= 1'b1;
    else        all_high_q <= all_high;
  end

  assign fall = all_high_q & ~all_high;
endmodule

// File: rtl/kbw_latch.sv
module kbw_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic all_high,
  input  logic level_mode,
  input  logic ack,
  output logic pend
);
  logic set_req, clr_ok;

  assign set_req = fall | (level_mode & ~all_high);
  assign clr_ok  = ack & (~level_mode | all_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
    else if (clr_ok)  pend <= 1'b0;
  end
endmodule

// File: rtl/kbw_irq_ctrl.sv
module kbw_irq_ctrl #(
  parameter int N_KEYS = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KEYS-1:0] key_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dbg_break,
  input  logic              brk_clr_en,
  output logic              irq,
  output logic              pend,
  output logic [N_KEYS-1:0] pullup_en
);
  import kbw_pkg::*;

  logic [N_KEYS-1:0] en_q;
  logic [N_KEYS-1:0] keys_s;
  logic              mode_q, mask_q;
  logic              all_high, fall, ack_ok;
  logic              wr_ctl, wr_en;

  assign wr_ctl = reg_wr & (reg_addr == ADDR_CTL);
  assign wr_en  = reg_wr & (reg_addr == ADDR_EN);
  assign ack_ok = wr_ctl & reg_wdata[CTL_ACK] & (~dbg_break | brk_clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= reg_wdata[N_KEYS-1:0];
      if (wr_ctl) begin
        mode_q <= reg_wdata[CTL_MODE];
        mask_q <= reg_wdata[CTL_MASK];
      end
    end
  end

  kbw_sync #(.W(N_KEYS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(key_n), .q(keys_s)
  );

  kbw_detect #(.N(N_KEYS)) det_i (
    .clk(clk), .rst_n(rst_n), .keys_s(keys_s), .en(en_q),
    .all_high(all_high), .fall(fall)
  );

  kbw_latch latch_i (
    .clk(clk), .rst_n(rst_n), .fall(fall), .all_high(all_high),
    .level_mode(mode_q), .ack(ack_ok), .pend(pend)
  );

  assign irq       = pend & ~mask_q;
  assign pullup_en = en_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTL) begin
      reg_rdata[CTL_MODE] = mode_q;
      reg_rdata[CTL_MASK] = mask_q;
      reg_rdata[CTL_PEND] = pend;
    end else begin
      reg_rdata[N_KEYS-1:0] = en_q;
    end
  end
endmodule

// File: rtl/kbw_irq_ctrl_chk.sv
module kbw_irq_ctrl_chk #(
  parameter int N = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          level_mode,
  input logic          all_high,
  input logic          dbg_break,
  input logic          brk_clr_en,
  input logic          pend,
  input logic          irq,
  input logic [N-1:0]  pullup_en
);
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend); // R9

  AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && reg_wr && !reg_addr && reg_wdata[2] && dbg_break && !brk_clr_en) |=> pend); // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && level_mode && !all_high) |=> pend); // R6

  AST_PULLUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> (pullup_en == $past(reg_wdata[N-1:0]))); // R3

  AST_NO_SET_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !level_mode && !all_high && $past(!all_high)) |=> !pend); // R5
endmodule

bind kbw_irq_ctrl kbw_irq_ctrl_chk #(.N(N_KEYS), .DW(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .level_mode(mode_q), .all_high(all_high),
  .dbg_break(dbg_break), .brk_clr_en(brk_clr_en), .pend(pend), .irq(irq),
  .pullup_en(pullup_en)
);

// File: tb/kbw_irq_ctrl_tb.sv
module kbw_irq_ctrl_tb_top;
  localparam int N = 8;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] key_n = '1;
  logic         reg_wr = 1'b0;
  logic         reg_addr = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic         dbg_break = 1'b0, brk_clr_en = 1'b0;
  logic         irq, pend;
  logic [N-1:0] pullup_en;
  int           n_run = 0, n_fail = 0;
  bit           done = 0;

  always #5 clk = ~clk;

  kbw_irq_ctrl #(.N_KEYS(N), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_break(dbg_break),
    .brk_clr_en(brk_clr_en), .irq(irq), .pend(pend), .pullup_en(pullup_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    idle(2);
    chk(pend == 0 && irq == 0, "R1 pend/irq after reset", {pend, irq}, 0);
    chk(pullup_en == 0, "R1 pullup after reset", pullup_en, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, r); chk(r == 0, "R1 ctrl read after reset", r, 0);
    rd(1'b1, r); chk(r == 0, "R1 enable read after reset", r, 0);

    // enable all, readback and pull-ups
    wr(1'b1, 8'hFF);
    rd(1'b1, r); chk(r == 8'hFF, "R2 enable readback", r, 8'hFF);
    chk(pullup_en == 8'hFF, "R3 pullup equals enable", pullup_en, 8'hFF);

    // R4 latency: single pin falls
    @(negedge clk); key_n = 8'hFE;
    idle(2); chk(pend == 0, "R4 pend not yet at edge 2", pend, 0);
    idle(1); chk(pend == 1, "R4 pend at edge 3", pend, 1);
    chk(irq == 1, "R9 irq follows pend unmasked", irq, 1);
    rd(1'b0, r); chk(r == 8'h08, "R10 status shows pend only", r, 8'h08);
    wr(1'b0, 8'h04); idle(1);
    chk(pend == 0, "R7 ack clears in edge mode", pend, 0);
    rd(1'b0, r); chk(r[2] == 0, "R7 ack bit reads 0", r, 0);
    key_n = '1; idle(4);
    chk(pend == 0, "R4 rising edge does not set", pend, 0);

    // sweep: each pin alone, then every other pin while held
    for (int i = 0; i < N; i++) begin
      key_n = ~(8'h01 << i); idle(4);
      chk(pend == 1, $sformatf("R4 pin %0d falling sets", i), pend, 1);
      wr(1'b0, 8'h04); idle(1);
      for (int j = 0; j < N; j++) begin
        if (j == i) continue;
        key_n = ~((8'h01 << i) | (8'h01 << j)); idle(4);
        chk(pend == 0, $sformatf("R5 pin %0d falls while %0d low", j, i), pend, 0);
        key_n = ~(8'h01 << i); idle(4);
      end
      key_n = '1; idle(4);
    end

    // sweep: disabled pin ignored
    for (int i = 0; i < N; i++) begin
      logic [7:0] ev;
      ev = ~(8'h01 << i);
      wr(1'b1, ev);
      chk(pullup_en == ev, $sformatf("R3 pullup mask %0h", ev), pullup_en, ev);
      key_n = ~(8'h01 << i); idle(4);
      chk(pend == 0, $sformatf("R2 disabled pin %0d ignored", i), pend, 0);
      key_n = '1; idle(4);
    end
    wr(1'b1, 8'hFF);

    // R8 break blocks ack
    key_n = 8'hEF; idle(4); key_n = '1; idle(4);
    chk(pend == 1, "R8 setup pend", pend, 1);
    dbg_break = 1'b1; brk_clr_en = 1'b0;
    wr(1'b0, 8'h04); idle(1);
    chk(pend == 1, "R8 ack ignored in break", pend, 1);
    brk_clr_en = 1'b1;
    wr(1'b0, 8'h04); idle(1);
    chk(pend == 0, "R8 ack honoured with clear enable", pend, 0);
    dbg_break = 1'b0; brk_clr_en = 1'b0;

    // R9 mask
    wr(1'b0, 8'h02);
    key_n = 8'h7F; idle(4); key_n = '1; idle(4);
    chk(pend == 1 && irq == 0, "R9 masked: pend set, irq low", {pend, irq}, 2);
    rd(1'b0, r); chk(r == 8'h0A, "R10 status mask+pend", r, 8'h0A);
    wr(1'b0, 8'h00); idle(1);
    chk(irq == 1, "R9 unmask raises irq", irq, 1);
    wr(1'b0, 8'h04); idle(1);

    // R6 level mode
    wr(1'b0, 8'h01);
    key_n = 8'hFB; idle(4);
    chk(pend == 1, "R6 low level sets", pend, 1);
    wr(1'b0, 8'h05); idle(2);
    chk(pend == 1, "R6 ack ignored while low", pend, 1);
    rd(1'b0, r); chk(r == 8'h09, "R10 status level+pend", r, 8'h09);
    key_n = '1; idle(4);
    chk(pend == 1, "R6 latch holds after release", pend, 1);
    wr(1'b0, 8'h05); idle(1);
    chk(pend == 0, "R6 ack clears once high", pend, 0);
    wr(1'b0, 8'h00);

    // R11 enable sequence with false request
    wr(1'b1, 8'h00);
    key_n = 8'hF7; idle(4);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h08); idle(2);
    chk(pend == 1 && irq == 0, "R11 false request masked", {pend, irq}, 2);
    wr(1'b0, 8'h06); idle(1);
    chk(pend == 0, "R11 ack drops false request", pend, 0);
    wr(1'b0, 8'h00); idle(3);
    chk(irq == 0 && pend == 0, "R11 no irq after unmask", {pend, irq}, 0);
    key_n = '1; idle(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule